// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs single transfers on a synchronous external memory bus on behalf of an internal requester. The requester presents an address, a set of transfer attributes, a read/write flag and write data. When the sequencer is idle it accepts the request. It then runs one bus cycle: a drive clock with a start strobe, a sample phase that lasts until the transfer is acknowledged, and a hold clock that keeps the bus stable before the next cycle. It returns the read data together with a one-clock completion pulse.

A small region decoder compares each request against a set of configurable address windows. Each window selects its own chip-select line. It also chooses whether the acknowledge comes from an internal wait-state counter or from the external device's acknowledge pin. An address that hits no window is run as a plain external transfer with no chip select. An address that hits more than one window is refused with an error. In that case no bus cycle takes place.

Top module: `ebus_seq`

## Requirements
- R1: After reset the block is idle: `bus_ts_n`=1, all `bus_cs_n` bits 1, `bus_doe`=0, `rsp_done`=0, `rsp_error`=0, `req_ready`=1.
- R2: In the clock after a request is accepted (the drive clock), `bus_ts_n` is 0 for exactly that one clock. In the same clock `bus_addr`/`bus_attr` equal the request, and `bus_rw` is 1 for a read and 0 for a write.
- R3: An access to a region with internal acknowledge and a wait count of 0 takes three clocks (drive, sample, hold). `rsp_done` is 1 only in the third clock.
- R4: For a region with internal acknowledge and wait count N (4-bit field), `rsp_done` is 1 in clock 3+N, counting the drive clock as 1. The level of `bus_ta_n` has no effect on such an access.
- R5: For an externally acknowledged access, the sample phase repeats until `bus_ta_n`=0 is seen at a rising edge. If the pin is first low in sample clock d (d=0 for the first), `rsp_done` is 1 in clock 3+d.
- R6: On a read, `rsp_rdata` in the done clock equals the `bus_din` value present at the rising edge where the acknowledge was taken.
- R7: On a write, `bus_doe`=1 and `bus_dout` equals the write data from the second clock through the hold clock. `bus_doe` is 0 in every other clock.
- R8: `bus_addr`, `bus_attr` and `bus_cs_n` stay at their drive-clock values through the whole sample phase and the hold clock.
- R9: Region i matches when its enable bit is 1 and (addr & mask_i) == (base_i & mask_i). A single match drives `bus_cs_n[i]`=0 for the access and applies that region's acknowledge source and wait count. Bit i of `cfg_int_ack` set to 1 selects internal acknowledge.
- R10: An address matching no region runs with external acknowledge and all `bus_cs_n` bits at 1.
- R11: An address matching two or more regions starts no bus cycle. In the clock after acceptance, `rsp_done`=1 and `rsp_error`=1 for one clock, with `bus_ts_n`=1 and all chip selects at 1.
- R12: `req_ready` is 1 only while idle, so a second request is not taken until the current access has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester has a transfer pending |
| req_ready | output | 1 | Sequencer idle; request taken when both are 1 |
| req_addr | input | ADDR_W | Transfer address |
| req_attr | input | ATTR_W | Transfer attributes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_error | output | 1 | Access refused (overlapping regions), valid with done |
| rsp_rdata | output | DATA_W | Read data, valid with done on a read |
| cfg_base | input | NUM_RGN*ADDR_W | Region base addresses, region i at bits i*ADDR_W |
| cfg_mask | input | NUM_RGN*ADDR_W | Region compare masks |
| cfg_en | input | NUM_RGN | Region enables |
| cfg_int_ack | input | NUM_RGN | 1 = internal acknowledge for region |
| cfg_wait | input | NUM_RGN*WAIT_W | Region wait counts |
| bus_addr | output | ADDR_W | Bus address |
| bus_attr | output | ATTR_W | Bus attributes |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ts_n | output | 1 | Transfer start strobe, active low |
| bus_ta_n | input | 1 | External acknowledge, active low |
| bus_cs_n | output | NUM_RGN | Chip selects, active low |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Read data from the bus |

## Verification
The assertions check the cycle-level protocol on every clock. They cover the single-clock start strobe, that an accepted request leads to a strobe or an error, and that address, attributes and chip selects stay stable through sample and hold. They also check that write enable follows a write strobe, that at most one chip select is active, and that a refused access stays quiet on the bus. Cycle counts for a given wait setting, the ignoring of the external pin in internally acknowledged regions, the exact read data captured at the acknowledge edge, and the decoding of overlaps, misses and disabled windows can only be shown by the bench scenarios. Those scenarios compare against a model of the region table.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_DRIVE  = 3'd1,
      ST_SAMPLE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_FAULT  = 3'd4
   } ebus_state_e;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_ONE  = 2'd1,
      HIT_MANY = 2'd2
   } ebus_hit_e;

endpackage

// File: rtl/ebus_rgn_dec.sv
module ebus_rgn_dec
   import ebus_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_RGN = 4,
   parameter int WAIT_W  = 4
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_RGN*ADDR_W-1:0] cfg_base,
   input  logic [NUM_RGN*ADDR_W-1:0] cfg_mask,
   input  logic [NUM_RGN-1:0]        cfg_en,
   input  logic [NUM_RGN-1:0]        cfg_int_ack,
   input  logic [NUM_RGN*WAIT_W-1:0] cfg_wait,
   output ebus_hit_e                 hit_kind,
   output logic [NUM_RGN-1:0]        hit_vec,
   output logic                      int_ack,
   output logic [WAIT_W-1:0]         wait_n
);

   localparam int CNT_W = $clog2(NUM_RGN + 1);

   logic [CNT_W-1:0] hit_cnt;

   for (genvar gi = 0; gi < NUM_RGN; gi++) begin : g_rgn
      logic [ADDR_W-1:0] base_m, addr_m;
      assign base_m     = cfg_base[gi*ADDR_W +: ADDR_W] & cfg_mask[gi*ADDR_W +: ADDR_W];
      assign addr_m     = addr & cfg_mask[gi*ADDR_W +: ADDR_W];
      assign hit_vec[gi] = cfg_en[gi] && (addr_m == base_m);
   end

   always_comb begin
      hit_cnt = '0;
      int_ack = 1'b0;
      wait_n  = '0;
      for (int i = 0; i < NUM_RGN; i++) begin
         hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
         if (hit_vec[i]) begin
            int_ack = int_ack | cfg_int_ack[i];
            wait_n  = wait_n | cfg_wait[i*WAIT_W +: WAIT_W];
         end
      end
   end

   always_comb begin
      if (hit_cnt == '0)
         hit_kind = HIT_NONE;
      else if (hit_cnt == CNT_W'(1))
         hit_kind = HIT_ONE;
      else
         hit_kind = HIT_MANY;
   end

endmodule

// File: rtl/ebus_wait_ctr.sv
module ebus_wait_ctr #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              run,
   output logic              expired
);

   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - WAIT_W'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
   import ebus_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int ATTR_W  = 4,
   parameter int NUM_RGN = 4,
   parameter int WAIT_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [ATTR_W-1:0]         req_attr,
   input  logic                      req_write,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic                      rsp_done,
   output logic                      rsp_error,
   output logic [DATA_W-1:0]         rsp_rdata,
   input  logic [NUM_RGN*ADDR_W-1:0] cfg_base,
   input  logic [NUM_RGN*ADDR_W-1:0] cfg_mask,
   input  logic [NUM_RGN-1:0]        cfg_en,
   input  logic [NUM_RGN-1:0]        cfg_int_ack,
   input  logic [NUM_RGN*WAIT_W-1:0] cfg_wait,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic [ATTR_W-1:0]         bus_attr,
   output logic                      bus_rw,
   output logic                      bus_ts_n,
   input  logic                      bus_ta_n,
   output logic [NUM_RGN-1:0]        bus_cs_n,
   output logic [DATA_W-1:0]         bus_dout,
   output logic                      bus_doe,
   input  logic [DATA_W-1:0]         bus_din
);

   if (ADDR_W < 1 || DATA_W < 1 || ATTR_W < 1) begin : g_bad_width
      $error("ebus_seq: widths must be at least 1");
   end
   if (NUM_RGN < 1 || NUM_RGN > 32) begin : g_bad_rgn
      $error("ebus_seq: NUM_RGN out of range");
   end
   if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait
      $error("ebus_seq: WAIT_W out of range");
   end

   ebus_state_e state_q, state_d;

   ebus_hit_e         hit_kind;
   logic [NUM_RGN-1:0] hit_vec;
   logic              dec_int_ack;
   logic [WAIT_W-1:0] dec_wait;

   logic [ADDR_W-1:0]  addr_q;
   logic [ATTR_W-1:0]  attr_q;
   logic               wr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [DATA_W-1:0]  rdata_q;
   logic [NUM_RGN-1:0] cs_q;
   logic               int_q;

   logic fire, ack, expired, active, data_phase;

   ebus_rgn_dec #(
      .ADDR_W (ADDR_W),
      .NUM_RGN(NUM_RGN),
      .WAIT_W (WAIT_W)
   ) u_dec (
      .addr       (req_addr),
      .cfg_base   (cfg_base),
      .cfg_mask   (cfg_mask),
      .cfg_en     (cfg_en),
      .cfg_int_ack(cfg_int_ack),
      .cfg_wait   (cfg_wait),
      .hit_kind   (hit_kind),
      .hit_vec    (hit_vec),
      .int_ack    (dec_int_ack),
      .wait_n     (dec_wait)
   );

   ebus_wait_ctr #(
      .WAIT_W(WAIT_W)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fire),
      .load_val((hit_kind == HIT_ONE) ? dec_wait : '0),
      .run     (state_q == ST_SAMPLE),
      .expired (expired)
   );

   assign fire = req_valid && (state_q == ST_IDLE);
   assign ack  = int_q ? expired : !bus_ta_n;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (fire) state_d = (hit_kind == HIT_MANY) ? ST_FAULT : ST_DRIVE;
         ST_DRIVE:  state_d = ST_SAMPLE;
         ST_SAMPLE: if (ack) state_d = ST_HOLD;
         ST_HOLD:   state_d = ST_IDLE;
         ST_FAULT:  state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         attr_q  <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         cs_q    <= '0;
         int_q   <= 1'b0;
      end else if (fire) begin
         addr_q  <= req_addr;
         attr_q  <= req_attr;
         wr_q    <= req_write;
         wdata_q <= req_wdata;
         cs_q    <= (hit_kind == HIT_ONE) ? hit_vec : '0;
         int_q   <= (hit_kind == HIT_ONE) && dec_int_ack;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if ((state_q == ST_SAMPLE) && ack && !wr_q)
         rdata_q <= bus_din;
   end

   assign active     = (state_q == ST_DRIVE) || (state_q == ST_SAMPLE) || (state_q == ST_HOLD);
   assign data_phase = (state_q == ST_SAMPLE) || (state_q == ST_HOLD);

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_done  = (state_q == ST_HOLD) || (state_q == ST_FAULT);
   assign rsp_error = (state_q == ST_FAULT);
   assign rsp_rdata = rdata_q;

   assign bus_addr = active ? addr_q : '0;
   assign bus_attr = active ? attr_q : '0;
   assign bus_rw   = active ? !wr_q : 1'b1;
   assign bus_ts_n = (state_q != ST_DRIVE);
   assign bus_cs_n = active ? ~cs_q : '1;
   assign bus_doe  = wr_q && data_phase;
   assign bus_dout = bus_doe ? wdata_q : '0;

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk
   import ebus_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ATTR_W  = 4,
   parameter int NUM_RGN = 4
) (
   input logic               clk,
   input logic               rst_n,
   input ebus_state_e        state_q,
   input logic               req_valid,
   input logic               req_ready,
   input logic               rsp_done,
   input logic               rsp_error,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [ATTR_W-1:0]  bus_attr,
   input logic               bus_rw,
   input logic               bus_ts_n,
   input logic [NUM_RGN-1:0] bus_cs_n,
   input logic               bus_doe
);

   p_ts_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ts_n |=> bus_ts_n);

   p_fire_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!bus_ts_n || rsp_error));

   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SAMPLE || state_q == ST_HOLD) |->
         ($stable(bus_addr) && $stable(bus_attr) && $stable(bus_cs_n)));

   p_write_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ts_n && !bus_rw) |=> bus_doe);

   p_idle_no_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_doe);

   p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> (bus_ts_n && (&bus_cs_n) && rsp_done));

   p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   p_done_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_error) |-> (!req_ready && $past(!req_ready)));

endmodule

bind ebus_seq ebus_seq_chk #(
   .ADDR_W (ADDR_W),
   .ATTR_W (ATTR_W),
   .NUM_RGN(NUM_RGN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state_q  (state_q),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .rsp_done (rsp_done),
   .rsp_error(rsp_error),
   .bus_addr (bus_addr),
   .bus_attr (bus_attr),
   .bus_rw   (bus_rw),
   .bus_ts_n (bus_ts_n),
   .bus_cs_n (bus_cs_n),
   .bus_doe  (bus_doe)
);

// File: tb/sim_ebus_seq.sv
`timescale 1ns/1ps
module sim_ebus_seq;

   localparam int AW = 32, DW = 32, TW = 4, NR = 4, WW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [AW-1:0]     req_addr = '0;
   logic [TW-1:0]     req_attr = '0;
   logic [DW-1:0]     req_wdata = '0, rsp_rdata, bus_dout, bus_din = '0;
   logic              rsp_done, rsp_error, bus_rw, bus_ts_n, bus_doe;
   logic              bus_ta_n = 1'b1;
   logic [AW-1:0]     bus_addr;
   logic [TW-1:0]     bus_attr;
   logic [NR-1:0]     bus_cs_n;
   logic [NR*AW-1:0]  cfg_base, cfg_mask;
   logic [NR-1:0]     cfg_en, cfg_int_ack;
   logic [NR*WW-1:0]  cfg_wait;

   logic [AW-1:0] m_base [NR];
   logic [AW-1:0] m_mask [NR];
   logic          m_en   [NR];
   logic          m_int  [NR];
   logic [WW-1:0] m_wait [NR];

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         cfg_base[i*AW +: AW] = m_base[i];
         cfg_mask[i*AW +: AW] = m_mask[i];
         cfg_en[i]            = m_en[i];
         cfg_int_ack[i]       = m_int[i];
         cfg_wait[i*WW +: WW] = m_wait[i];
      end
   end

   int checks = 0, errors = 0;

   ebus_seq #(.ADDR_W(AW), .DATA_W(DW), .ATTR_W(TW), .NUM_RGN(NR), .WAIT_W(WW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_attr(req_attr), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
      .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
      .cfg_int_ack(cfg_int_ack), .cfg_wait(cfg_wait),
      .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_rw(bus_rw), .bus_ts_n(bus_ts_n),
      .bus_ta_n(bus_ta_n), .bus_cs_n(bus_cs_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_hits(input logic [AW-1:0] a, output int idx);
      int n = 0;
      idx = -1;
      for (int i = 0; i < NR; i++)
         if (m_en[i] && ((a & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
            n++;
            idx = i;
         end
      return n;
   endfunction

   task automatic check_idle(input string req);
      chk(req_ready == 1'b1, req, req_ready, 1);
      chk(bus_ts_n == 1'b1 && bus_cs_n == '1 && bus_doe == 1'b0, req,
          {bus_ts_n, bus_cs_n, bus_doe}, {1'b1, {NR{1'b1}}, 1'b0});
      chk(rsp_done == 1'b0 && rsp_error == 1'b0, req, {rsp_done, rsp_error}, 0);
   endtask

   // dly: first sample clock with external acknowledge low; ta_low: hold pin low in internal regions
   task automatic access(input logic [AW-1:0] a, input bit wr, input logic [TW-1:0] at,
                         input logic [DW-1:0] wd, input int dly, input bit ta_low);
      int idx, n, exp_cyc, c;
      bit internal;
      logic [NR-1:0] exp_cs;
      logic [DW-1:0] last_din;
      n = model_hits(a, idx);
      internal = (n == 1) && m_int[idx];
      exp_cs = (n == 1) ? ~(NR'(1) << idx) : '1;
      exp_cyc = internal ? 3 + int'(m_wait[idx]) : 3 + dly;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_attr = at; req_wdata = wd;
      bus_ta_n = internal && ta_low ? 1'b0 : 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (n > 1) begin
         chk(rsp_done && rsp_error, "R11", {rsp_done, rsp_error}, 2'b11);
         chk(bus_ts_n && bus_cs_n == '1, "R11", {bus_ts_n, bus_cs_n}, {1'b1, {NR{1'b1}}});
         @(negedge clk);
         check_idle("R11");
         return;
      end
      c = 1;
      last_din = bus_din;
      forever begin
         if (c == 1) begin
            chk(bus_ts_n == 1'b0, "R2", bus_ts_n, 0);
            chk(bus_rw == !wr, "R2", bus_rw, !wr);
            chk(bus_doe == 1'b0, "R7", bus_doe, 0);
         end else begin
            chk(bus_ts_n == 1'b1, "R2", bus_ts_n, 1);
            if (wr) chk(bus_doe && bus_dout == wd, "R7", bus_dout, wd);
         end
         chk(bus_addr == a && bus_attr == at, "R8", bus_addr, a);
         chk(bus_cs_n == exp_cs, (n == 1) ? "R9" : "R10", bus_cs_n, exp_cs);
         chk(req_ready == 1'b0, "R12", req_ready, 0);
         if (rsp_done) break;
         if (c > exp_cyc + 2) break;
         if (c >= 2 && !internal) bus_ta_n = ((c - 2) == dly) ? 1'b0 : 1'b1;
         bus_din = $urandom;
         last_din = bus_din;
         c++;
         @(negedge clk);
      end
      chk(c == exp_cyc, internal ? ((m_wait[idx] == 0) ? "R3" : "R4") : "R5", c, exp_cyc);
      chk(rsp_error == 1'b0, "R11", rsp_error, 0);
      if (!wr) chk(rsp_rdata == last_din, "R6", rsp_rdata, last_din);
      bus_ta_n = 1'b1;
      @(negedge clk);
      check_idle("R12");
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_base[0] = 32'h1000_0000; m_mask[0] = 32'hF000_0000; m_en[0] = 1; m_int[0] = 1; m_wait[0] = 0;
      m_base[1] = 32'h2000_0000; m_mask[1] = 32'hF000_0000; m_en[1] = 1; m_int[1] = 1; m_wait[1] = 5;
      m_base[2] = 32'h3000_0000; m_mask[2] = 32'hF000_0000; m_en[2] = 1; m_int[2] = 0; m_wait[2] = 7;
      m_base[3] = 32'h3000_0000; m_mask[3] = 32'hFF00_0000; m_en[3] = 1; m_int[3] = 1; m_wait[3] = 2;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");

      access(32'h1000_0040, 1'b0, 4'h3, '0, 0, 1'b0);            // R3 zero-wait internal read
      access(32'h2000_1000, 1'b1, 4'h5, 32'hCAFE_0001, 0, 1'b1); // R4 wait 5, pin low ignored; R7
      access(32'h3100_0008, 1'b0, 4'h1, '0, 0, 1'b0);            // R5 external, acknowledge at once
      access(32'h3100_000C, 1'b0, 4'h2, '0, 3, 1'b0);            // R5 R6 external, 3 waits
      access(32'h4000_0000, 1'b1, 4'h7, 32'h1234_5678, 1, 1'b0); // R10 no match, external
      access(32'h3000_1234, 1'b0, 4'h0, '0, 0, 1'b0);            // R11 overlap
      m_en[3] = 0;
      access(32'h3000_1234, 1'b0, 4'h0, '0, 2, 1'b0);            // R9 disabled window no longer hits
      m_en[3] = 1;
      m_wait[0] = 4'hF;
      access(32'h1FFF_FFFC, 1'b0, 4'hA, '0, 0, 1'b1);            // R4 largest wait count

      for (int k = 0; k < 60; k++) begin
         logic [AW-1:0] a;
         m_wait[0] = WW'($urandom_range(0, 15));
         m_wait[1] = WW'($urandom_range(0, 15));
         m_en[3]   = $urandom_range(0, 1) == 1;
         a = {4'($urandom_range(1, 5)), 4'($urandom_range(0, 1)), 24'($urandom)};
         access(a, $urandom_range(0, 1) == 1, TW'($urandom), $urandom,
                $urandom_range(0, 4), $urandom_range(0, 1) == 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule